// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Empty and Almost-Full Flags

This block is a 64-word by 36-bit FIFO that links two unrelated clock domains. The write side has its own clock and reports two active-low flags: full and almost-full. The read side has its own clock and also reports two active-low flags: empty and almost-empty. One offset value X sets both almost thresholds. X is chosen from four presets by a 2-bit select, and each domain latches it while reset is held low.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other domain through two flops. A flag is asserted by activity in its own domain, and that happens on the clock edge of the operation itself. A flag is released by activity in the far domain, and that release waits until the second rising edge of the local clock after the far-side event. Read data is registered. It updates on the read clock edge that accepts a read.

Top module: `xclk_fifo`

## Requirements
- R1: Words are read out in the order they were written, with all 36 bits intact. Up to 64 words can be held.
- R2: `empty_n_o` is low when the read side sees a count of 0. A read that takes the last word drives it low on that same read clock edge.
- R3: `full_n_o` is low when the write side sees a count of 64. A write that stores the 64th word drives it low on that same write clock edge.
- R4: `aempty_n_o` is low when the read side sees X or fewer words. It is high at X+1 or more. A read that brings the count down to X drives it low on that read edge.
- R5: `afull_n_o` is low when the write side sees 64-X or more words. It is high at 63-X or fewer. A write that brings the count up to 64-X drives it low on that write edge.
- R6: X is latched from `ofs_sel_i` on each clock while `rst_ni` is low, using these codes: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 24, 2'b11 gives 32.
- R7: After a write raises the count to 1 (or to X+1), `empty_n_o` (or `aempty_n_o`) stays low through the first rising read clock edge and goes high on the second.
- R8: After a read lowers the count to 63 (or to 63-X), `full_n_o` (or `afull_n_o`) stays low through the first rising write clock edge and goes high on the second.
- R9: A write while `full_n_o` is low changes neither storage nor the pointer. A read while `empty_n_o` is low leaves `rd_data_o` unchanged.
- R10: While `rst_ni` is low, `empty_n_o` and `aempty_n_o` are low and `full_n_o` and `afull_n_o` are high. `rst_ni` is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| ofs_sel_i | input | 2 | Almost-threshold preset select, latched during reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 36 | Write data |
| full_n_o | output | 1 | Full, active low (write domain) |
| afull_n_o | output | 1 | Almost-full, active low (write domain) |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 36 | Registered read data |
| empty_n_o | output | 1 | Empty, active low (read domain) |
| aempty_n_o | output | 1 | Almost-empty, active low (read domain) |

## Verification
The hardest case to reach is the delayed release. A write lands in one domain, and the bench must then check the flag in the other domain at exactly the first and second local edges that follow. The two clocks run at unrelated periods and are offset so that write edges fall on even nanoseconds and read edges fall on odd ones. Every sample is taken half a nanosecond after an edge. This fixes which far-side edge counts as the first edge, so the bench can check each release, for empty, almost-empty, full and almost-full, one edge at a time under every preset.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

  // preset offsets are multiples of the step: sel 0..3 -> 1..4 steps
  function automatic logic [31:0] preset_ofs(logic [1:0] sel, int unsigned step);
    return (32'(sel) + 32'd1) * step;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xclk_fifo_wr.sv
module xclk_fifo_wr
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned OFS_STEP = 8,
  localparam int unsigned PW      = ADDR_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    ofs_sel_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_i,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          wr_fire_o,
  output logic          full_n_o,
  output logic          afull_n_o,
  output logic [PW-1:0] ofs_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wgray_q, ofs_q;
  logic [PW-1:0] rbin, cnt, wbin_nxt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ofs_q <= PW'(preset_ofs(ofs_sel_i, OFS_STEP));
  end

  always_comb begin
    rbin      = PW'(gray2bin(32'(rgray_i)));
    cnt       = wbin_q - rbin;
    full_n_o  = (cnt != PW'(DEPTH));
    afull_n_o = (cnt < (PW'(DEPTH) - ofs_q));
    wr_fire_o = wr_en_i & full_n_o;
    wbin_nxt  = wbin_q + PW'(wr_fire_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(bin2gray(32'(wbin_nxt)));
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign ofs_o   = ofs_q;
endmodule

// File: rtl/xclk_fifo_rd.sv
module xclk_fifo_rd
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned OFS_STEP = 8,
  localparam int unsigned PW      = ADDR_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    ofs_sel_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_i,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          rd_fire_o,
  output logic          empty_n_o,
  output logic          aempty_n_o
);
  logic [PW-1:0] rbin_q, rgray_q, ofs_q;
  logic [PW-1:0] wbin, cnt, rbin_nxt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ofs_q <= PW'(preset_ofs(ofs_sel_i, OFS_STEP));
  end

  always_comb begin
    wbin       = PW'(gray2bin(32'(wgray_i)));
    cnt        = wbin - rbin_q;
    empty_n_o  = (cnt != '0);
    aempty_n_o = (cnt > ofs_q);
    rd_fire_o  = rd_en_i & empty_n_o;
    rbin_nxt   = rbin_q + PW'(rd_fire_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(bin2gray(32'(rbin_nxt)));
    end
  end

  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned OFS_STEP = 8
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ofs_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_n_o,
  output logic              afull_n_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_n_o,
  output logic              aempty_n_o
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin, wgray, wgray_s, rbin, rgray, rgray_s, wr_ofs;
  logic          wr_fire, rd_fire;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_data_q;

  xclk_fifo_wr #(.ADDR_W(ADDR_W), .OFS_STEP(OFS_STEP)) i_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .ofs_sel_i(ofs_sel_i), .wr_en_i(wr_en_i),
    .rgray_i(rgray_s), .wbin_o(wbin), .wgray_o(wgray), .wr_fire_o(wr_fire),
    .full_n_o(full_n_o), .afull_n_o(afull_n_o), .ofs_o(wr_ofs)
  );

  xclk_fifo_rd #(.ADDR_W(ADDR_W), .OFS_STEP(OFS_STEP)) i_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .ofs_sel_i(ofs_sel_i), .rd_en_i(rd_en_i),
    .wgray_i(wgray_s), .rbin_o(rbin), .rgray_o(rgray), .rd_fire_o(rd_fire),
    .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o)
  );

  // write pointer into read domain
  xclk_fifo_sync #(.W(PW)) i_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  // read pointer into write domain
  xclk_fifo_sync #(.W(PW)) i_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_fire) mem_q[wbin[ADDR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_fire) rd_data_q <= mem_q[rbin[ADDR_W-1:0]];
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned OFS_STEP = 8,
  localparam int unsigned PW      = ADDR_W + 1
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              full_n_o,
  input logic              afull_n_o,
  input logic              empty_n_o,
  input logic              aempty_n_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [PW-1:0]     wbin,
  input logic [PW-1:0]     wr_ofs
);
  assert_no_overflow_R9: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && !full_n_o) |=> $stable(wbin));

  assert_no_underflow_R9: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_n_o) |=> $stable(rd_data_o));

  assert_full_by_write_R3: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $fell(full_n_o) |-> $past(wr_en_i));

  assert_empty_by_read_R2: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $fell(empty_n_o) |-> $past(rd_en_i));

  assert_aempty_covers_empty_R4: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !empty_n_o |-> !aempty_n_o);

  assert_afull_covers_full_R5: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !full_n_o |-> !afull_n_o);

  assert_ofs_preset_R6: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_ofs == PW'(OFS_STEP)) || (wr_ofs == PW'(2 * OFS_STEP)) ||
    (wr_ofs == PW'(3 * OFS_STEP)) || (wr_ofs == PW'(4 * OFS_STEP)));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_STEP(OFS_STEP)) i_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .full_n_o(full_n_o), .afull_n_o(afull_n_o),
  .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o),
  .rd_data_o(rd_data_o), .wbin(wbin), .wr_ofs(wr_ofs)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/100ps
module test_xclk_fifo;
  localparam int DEPTH = 64;

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        full_n, afull_n, empty_n, aempty_n;
  logic [35:0] rd_data;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // 250 MHz write clock, edges on even ns; read clock edges on odd ns
  always #2 wr_clk = ~wr_clk;
  initial begin #1; rd_clk = 1'b1; forever #3 rd_clk = ~rd_clk; end

  xclk_fifo i_xclk_fifo (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .ofs_sel_i(sel),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_n_o(full_n), .afull_n_o(afull_n),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_n_o(empty_n), .aempty_n_o(aempty_n)
  );

  // stimulus/expectation table: {preset select, expected offset}
  localparam logic [7:0] VEC [4] = '{ {2'd0, 6'd8}, {2'd1, 6'd16}, {2'd2, 6'd24}, {2'd3, 6'd32} };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(int k, int v);
    return {4'(v + 1), 32'(k * 32'h0101_0013 + 32'h5a)};
  endfunction

  task automatic do_reset(input logic [1:0] s);
    sel = s;
    rst_n = 1'b0;
    repeat (4) @(posedge wr_clk);
    repeat (3) @(posedge rd_clk);
    #0.5;
    check("R10 empty_n in reset", 36'(empty_n), 36'd0);
    check("R10 aempty_n in reset", 36'(aempty_n), 36'd0);
    check("R10 full_n in reset", 36'(full_n), 36'd1);
    check("R10 afull_n in reset", 36'(afull_n), 36'd1);
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (3) @(posedge rd_clk);
  endtask

  task automatic wr_word(input logic [35:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge wr_clk);
    #0.5 wr_en = 1'b0;
  endtask

  task automatic rd_word();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    #0.5 rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #0.5;
  endtask

  initial begin
    for (int v = 0; v < 4; v++) begin
      int x;
      x = int'(VEC[v][5:0]);
      do_reset(VEC[v][7:6]);

      // fill, watching releases on the read side and assertions on the write side
      for (int k = 0; k < DEPTH; k++) begin
        wr_word(pat(k, v));
        check("R5 afull_n after write", 36'(afull_n), 36'(k + 1 < DEPTH - x));
        check("R3 full_n after write", 36'(full_n), 36'(k + 1 != DEPTH));
        if (k == 0 || k == x) begin
          check("R7 no release before first read edge", 36'(k == 0 ? empty_n : aempty_n), 36'd0);
          @(posedge rd_clk); #0.5;
          check("R7 still low on first read edge", 36'(k == 0 ? empty_n : aempty_n), 36'd0);
          @(posedge rd_clk); #0.5;
          check("R7 released on second read edge", 36'(k == 0 ? empty_n : aempty_n), 36'd1);
        end
      end
      settle();
      check("R4 aempty_n high when full", 36'(aempty_n), 36'd1);

      // write while full is dropped
      wr_word(36'hB_ADBA_DBAD);
      check("R9 full_n holds after write when full", 36'(full_n), 36'd0);
      settle();

      // drain, checking order, immediate assertions and delayed releases
      for (int k = 0; k < DEPTH; k++) begin
        int left;
        rd_word();
        left = DEPTH - 1 - k;
        check("R1 read data order", rd_data, pat(k, v));
        check("R4 aempty_n after read", 36'(aempty_n), 36'(left > x));
        check("R2 empty_n after read", 36'(empty_n), 36'(left != 0));
        if (left == DEPTH - 1 || left == DEPTH - 1 - x) begin
          @(posedge wr_clk); #0.5;
          check("R8 still low on first write edge", 36'(left == DEPTH - 1 ? full_n : afull_n), 36'd0);
          @(posedge wr_clk); #0.5;
          check("R8 released on second write edge", 36'(left == DEPTH - 1 ? full_n : afull_n), 36'd1);
        end
      end

      // read while empty is dropped
      rd_word();
      check("R9 rd_data holds on read when empty", rd_data, pat(DEPTH - 1, v));
      check("R9 empty_n stays low", 36'(empty_n), 36'd0);
      settle();
    end

    // directed: a pointer that wrapped still delivers correct data after the refill
    wr_word(36'h1_2345_6789);
    settle();
    rd_word();
    check("R1 data after wrap", rd_data, 36'h1_2345_6789);
    check("R2 empty after single word", 36'(empty_n), 36'd0);

    // directed: reset mid-traffic brings flags back to idle and picks a new preset
    wr_word(36'h0);
    do_reset(2'd1);
    for (int k = 0; k < 17; k++) wr_word(pat(k, 9));
    settle();
    check("R6 preset 16: seventeen words lift aempty_n", 36'(aempty_n), 36'd1);
    rd_word();
    check("R6 preset 16: sixteen words drop aempty_n", 36'(aempty_n), 36'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule